// File: doc/BRIEF.md
# Parallel NOR Flash Control-Pin Sequencer

This block sits behind the control pins of a parallel NOR flash device. Once per clock it samples chip enable, output enable, write enable, the hardware reset pin and the address bus. It also receives a busy flag from the embedded program/erase engine. From these it chooses the pin mode (standby, output disable, read or hardware reset) and drives several signals: the data-bus output enable, a ready/busy status, a one-cycle abort request to the command engine, a write-accept strobe and an automatic-sleep flag. All timing is counted in clock cycles and set by parameters.

A hardware reset counts only when the reset pin is sampled low on `T_RP` consecutive edges. Shorter pulses have no effect. A valid reset aborts any running operation and takes the device off the bus. It then runs an internal recovery whose length depends on whether an embedded operation was running at that moment. Reads and writes come back only after recovery has finished and the reset pin has been high for `T_RH` edges. Read data reaches the bus only after two conditions hold: chip enable has been low long enough, and the address has been stable long enough. If the address then stays unchanged for a further delay, the block raises its sleep flag and keeps the last data on the bus.

Top module: `flpm_ctrl`

## Requirements
- R1: After the system reset is released, `dq_oe_o`, `abort_o`, `sleep_o` and `wr_ok_o` are 0, `ready_o` is 1 while `op_busy` is 0, and `mode_o` is 0 while chip enable is high.
- R2: On the `T_RP`-th consecutive edge that samples `pin_rst_n` low, the reset becomes valid. From that edge until `pin_rst_n` is sampled high, `mode_o` is 3, and `dq_oe_o` and `wr_ok_o` are 0. `abort_o` is 1 for exactly the one cycle that follows the validating edge.
- R3: A low pulse on `pin_rst_n` that lasts fewer than `T_RP` sampled edges is ignored: there is no abort, `mode_o` never becomes 3, and a read in progress keeps `dq_oe_o` at 1.
- R4: If `op_busy` is 1 at the validating edge, `ready_o` (1 = ready, 0 = busy) stays 0 for `T_RDY_EMB` edges after that edge, whatever `op_busy` does meanwhile, and follows `!op_busy` afterwards.
- R5: If `op_busy` is 0 at the validating edge, `ready_o` stays 1. Writes and reads stay blocked until `T_RDY_IDLE` edges after the validating edge.
- R6: After a valid reset, `wr_ok_o` and reads stay blocked until the `T_RH`-th edge after the first edge that samples `pin_rst_n` high.
- R7: While `chip_en_n` is 1, `mode_o` is 0 and `dq_oe_o` is 0, whatever the level of `out_en_n`.
- R8: `dq_oe_o` rises only after `T_CE` consecutive edges have sampled `chip_en_n` low while nothing blocks the block. Counting restarts after standby and after reset recovery.
- R9: An address change seen at an edge drops `dq_oe_o` after that edge. `dq_oe_o` returns once `T_ACC` consecutive edges have sampled the new address.
- R10: `sleep_o` is 1 once `T_ACC + T_SLP_X` consecutive edges have sampled the same address, whatever the levels of chip, output and write enable. It is 0 after any edge that samples a new address. While sleeping, read data stays enabled on the bus.
- R11: With `chip_en_n` 0, reset inactive and `out_en_n` 1, `mode_o` is 1 and `dq_oe_o` is 0. With `out_en_n` 0 and reset inactive, `mode_o` is 2.
- R12: Deselecting the chip does not stop an embedded operation. While `op_busy` is 1 and no reset is under way, `ready_o` is 0 and `abort_o` stays 0.
- R13: `wr_ok_o` is 1 exactly when `chip_en_n` and `wr_en_n` are both 0 and no reset, recovery or `T_RH` wait is blocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| chip_en_n | input | 1 | Chip enable pin, active low |
| out_en_n | input | 1 | Output enable pin, active low |
| wr_en_n | input | 1 | Write enable pin, active low |
| pin_rst_n | input | 1 | Hardware reset pin, active low |
| addr | input | AW | Address bus |
| op_busy | input | 1 | Embedded program/erase running |
| dq_oe_o | output | 1 | Data bus output enable |
| ready_o | output | 1 | Ready/busy status, 1 = ready |
| abort_o | output | 1 | One-cycle abort request to the command engine |
| sleep_o | output | 1 | Automatic sleep active |
| wr_ok_o | output | 1 | Write command strobe accepted |
| mode_o | output | 2 | Pin mode: 0 standby, 1 output disable, 2 read, 3 reset |

## Verification
Each fault in the internal counters shows up at the ports in a fixed way. A reset-validation counter that is off by one either aborts on a pulse one edge too short or misses the `T_RP`-th edge. That is visible on `abort_o` and `mode_o` in the very cycle concerned. A wrong recovery load or a wrong embedded flag shifts the rising edge of `ready_o` or of `wr_ok_o` by whole cycles, or swaps the long and short recovery times. A stability or chip-enable counter that does not restart moves the rise of `dq_oe_o` or `sleep_o` one or more edges away from its boundary. So the bench samples each transition at the edge before its boundary and again at the boundary edge itself.

// File: rtl/flpm_pkg.sv
package flpm_pkg;

    // Pin mode as reported on mode_o
    typedef enum logic [1:0] {
        PM_STBY  = 2'd0,
        PM_ODIS  = 2'd1,
        PM_READ  = 2'd2,
        PM_RESET = 2'd3
    } pin_mode_e;

    // Bits needed to hold the count 0..maxval
    function automatic int unsigned cnt_bits(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/flpm_rst_seq.sv
// Hardware-reset pin qualifier and recovery sequencer
module flpm_rst_seq
    import flpm_pkg::*;
#(
    parameter int unsigned T_RP       = 4,
    parameter int unsigned T_RH       = 3,
    parameter int unsigned T_RDY_EMB  = 20,
    parameter int unsigned T_RDY_IDLE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_rst_n,
    input  logic op_busy,
    output logic rst_in,
    output logic blk,
    output logic ready,
    output logic abort
);
    localparam int unsigned RDY_MAX = (T_RDY_EMB > T_RDY_IDLE) ? T_RDY_EMB : T_RDY_IDLE;
    localparam int unsigned CW_LOW  = cnt_bits(T_RP);
    localparam int unsigned CW_RDY  = cnt_bits(RDY_MAX);
    localparam int unsigned CW_RH   = cnt_bits(T_RH);

    typedef struct packed {
        logic [CW_LOW-1:0] low;   // consecutive low samples, saturating
        logic [CW_RDY-1:0] rdy;   // recovery cycles left
        logic [CW_RH-1:0]  rh;    // post-release wait cycles left
        logic              emb;   // reset hit a running operation
        logic              abort;
    } seq_t;

    seq_t seq_d, seq_q;
    logic valid_now;

    always_comb begin
        seq_d       = seq_q;
        seq_d.abort = 1'b0;
        valid_now   = !pin_rst_n && (seq_q.low == CW_LOW'(T_RP - 1));

        if (pin_rst_n) begin
            seq_d.low = '0;
        end else if (seq_q.low != CW_LOW'(T_RP)) begin
            seq_d.low = seq_q.low + CW_LOW'(1);
        end

        if (valid_now) begin
            seq_d.abort = 1'b1;
            seq_d.emb   = op_busy;
            seq_d.rdy   = op_busy ? CW_RDY'(T_RDY_EMB) : CW_RDY'(T_RDY_IDLE);
        end else if (seq_q.rdy != '0) begin
            seq_d.rdy = seq_q.rdy - CW_RDY'(1);
        end

        if (pin_rst_n && (seq_q.low == CW_LOW'(T_RP))) begin
            seq_d.rh = CW_RH'(T_RH);
        end else if (seq_q.rh != '0) begin
            seq_d.rh = seq_q.rh - CW_RH'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rst_in = (seq_q.low == CW_LOW'(T_RP));
    assign blk    = rst_in || (seq_q.rdy != '0) || (seq_q.rh != '0);
    assign ready  = (seq_q.rdy != '0) ? !seq_q.emb : !op_busy;
    assign abort  = seq_q.abort;

endmodule

// File: rtl/flpm_read_timer.sv
// Chip-enable access timer, address stability and automatic sleep
module flpm_read_timer
    import flpm_pkg::*;
#(
    parameter int unsigned AW    = 8,
    parameter int unsigned T_ACC = 5,
    parameter int unsigned T_CE  = 3,
    parameter int unsigned T_SLP = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          blk,
    input  logic [AW-1:0] addr,
    output logic          data_rdy,
    output logic          sleep
);
    localparam int unsigned CW_S = cnt_bits(T_SLP);
    localparam int unsigned CW_C = cnt_bits(T_CE);

    typedef struct packed {
        logic [AW-1:0]   addr;   // address seen at the last edge
        logic [CW_S-1:0] stab;   // consecutive edges with this address
        logic [CW_C-1:0] cen;    // consecutive unblocked selected edges
    } rt_t;

    rt_t rt_d, rt_q;

    always_comb begin
        rt_d      = rt_q;
        rt_d.addr = addr;

        if (addr != rt_q.addr) begin
            rt_d.stab = CW_S'(1);
        end else if (rt_q.stab != CW_S'(T_SLP)) begin
            rt_d.stab = rt_q.stab + CW_S'(1);
        end

        if (ce_n || blk) begin
            rt_d.cen = '0;
        end else if (rt_q.cen != CW_C'(T_CE)) begin
            rt_d.cen = rt_q.cen + CW_C'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rt_q <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign data_rdy = (rt_q.cen == CW_C'(T_CE)) && (rt_q.stab >= CW_S'(T_ACC));
    assign sleep    = (rt_q.stab == CW_S'(T_SLP));

endmodule

// File: rtl/flpm_ctrl.sv
// Control-pin mode decoder and reset sequencer for a parallel NOR flash
module flpm_ctrl
    import flpm_pkg::*;
#(
    parameter int unsigned AW         = 8,
    parameter int unsigned T_RP       = 4,
    parameter int unsigned T_RH       = 3,
    parameter int unsigned T_RDY_EMB  = 20,
    parameter int unsigned T_RDY_IDLE = 8,
    parameter int unsigned T_ACC      = 5,
    parameter int unsigned T_CE       = 3,
    parameter int unsigned T_SLP_X    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_en_n,
    input  logic          out_en_n,
    input  logic          wr_en_n,
    input  logic          pin_rst_n,
    input  logic [AW-1:0] addr,
    input  logic          op_busy,
    output logic          dq_oe_o,
    output logic          ready_o,
    output logic          abort_o,
    output logic          sleep_o,
    output logic          wr_ok_o,
    output logic [1:0]    mode_o
);
    localparam int unsigned T_SLP = T_ACC + T_SLP_X;

    logic      rst_in, blk, data_rdy;
    pin_mode_e mode;

    flpm_rst_seq #(
        .T_RP       (T_RP),
        .T_RH       (T_RH),
        .T_RDY_EMB  (T_RDY_EMB),
        .T_RDY_IDLE (T_RDY_IDLE)
    ) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_rst_n (pin_rst_n),
        .op_busy   (op_busy),
        .rst_in    (rst_in),
        .blk       (blk),
        .ready     (ready_o),
        .abort     (abort_o)
    );

    flpm_read_timer #(
        .AW    (AW),
        .T_ACC (T_ACC),
        .T_CE  (T_CE),
        .T_SLP (T_SLP)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (chip_en_n),
        .blk      (blk),
        .addr     (addr),
        .data_rdy (data_rdy),
        .sleep    (sleep_o)
    );

    always_comb begin
        if (rst_in)         mode = PM_RESET;
        else if (chip_en_n) mode = PM_STBY;
        else if (out_en_n)  mode = PM_ODIS;
        else                mode = PM_READ;
    end

    assign mode_o  = mode;
    assign dq_oe_o = data_rdy && !blk && !chip_en_n && !out_en_n;
    assign wr_ok_o = !blk && !chip_en_n && !wr_en_n;

endmodule

// File: rtl/flpm_ctrl_chk.sv
// Port-level properties of flpm_ctrl
module flpm_ctrl_chk #(
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chip_en_n,
    input logic          out_en_n,
    input logic          wr_en_n,
    input logic          pin_rst_n,
    input logic [AW-1:0] addr,
    input logic          dq_oe_o,
    input logic          wr_ok_o,
    input logic          abort_o,
    input logic          sleep_o,
    input logic [1:0]    mode_o
);
    logic [AW-1:0] addr_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_prev <= '0;
        else        addr_prev <= addr;
    end

    p_abort_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

    p_abort_pin_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (!pin_rst_n && mode_o == 2'd3));

    p_reset_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |-> (!dq_oe_o && !wr_ok_o));

    p_standby_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en_n |-> (!dq_oe_o && mode_o != 2'd1 && mode_o != 2'd2));

    p_odis_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dq_oe_o);

    p_wr_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok_o |-> (!chip_en_n && !wr_en_n));

    p_sleep_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != addr_prev) |=> !sleep_o);

endmodule

bind flpm_ctrl flpm_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en_n (chip_en_n),
    .out_en_n  (out_en_n),
    .wr_en_n   (wr_en_n),
    .pin_rst_n (pin_rst_n),
    .addr      (addr),
    .dq_oe_o   (dq_oe_o),
    .wr_ok_o   (wr_ok_o),
    .abort_o   (abort_o),
    .sleep_o   (sleep_o),
    .mode_o    (mode_o)
);

// File: tb/flpm_ctrl_bench.sv
module flpm_ctrl_bench;
    localparam int unsigned AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chip_en_n, out_en_n, wr_en_n, pin_rst_n, op_busy;
    logic [AW-1:0] addr;
    logic          dq_oe_o, ready_o, abort_o, sleep_o, wr_ok_o;
    logic [1:0]    mode_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    flpm_ctrl #(
        .AW(AW), .T_RP(4), .T_RH(3), .T_RDY_EMB(20), .T_RDY_IDLE(8),
        .T_ACC(5), .T_CE(3), .T_SLP_X(2)
    ) u_flpm_ctrl (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
        .wr_en_n(wr_en_n), .pin_rst_n(pin_rst_n), .addr(addr), .op_busy(op_busy),
        .dq_oe_o(dq_oe_o), .ready_o(ready_o), .abort_o(abort_o),
        .sleep_o(sleep_o), .wr_ok_o(wr_ok_o), .mode_o(mode_o)
    );

    typedef struct packed {
        logic       ce_n;
        logic       oe_n;
        logic       we_n;
        logic [7:0] adr;
        logic [3:0] n;
        logic       dq;
        logic [1:0] mode;
        logic       slp;
        logic       wr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 1'b1, 8'h00, 4'd7, 1'b0, 2'd0, 1'b1, 1'b0}, // R10 sleep while deselected
        '{1'b0, 1'b0, 1'b1, 8'h00, 4'd2, 1'b0, 2'd2, 1'b1, 1'b0}, // R8 one edge short
        '{1'b0, 1'b0, 1'b1, 8'h00, 4'd1, 1'b1, 2'd2, 1'b1, 1'b0}, // R8 boundary, data held in sleep
        '{1'b0, 1'b0, 1'b1, 8'h55, 4'd1, 1'b0, 2'd2, 1'b0, 1'b0}, // R9 change drops data
        '{1'b0, 1'b0, 1'b1, 8'h55, 4'd3, 1'b0, 2'd2, 1'b0, 1'b0}, // R9 one edge short
        '{1'b0, 1'b0, 1'b1, 8'h55, 4'd1, 1'b1, 2'd2, 1'b0, 1'b0}, // R9 boundary
        '{1'b0, 1'b0, 1'b1, 8'h55, 4'd1, 1'b1, 2'd2, 1'b0, 1'b0}, // R10 one edge short
        '{1'b0, 1'b0, 1'b1, 8'h55, 4'd1, 1'b1, 2'd2, 1'b1, 1'b0}, // R10 boundary
        '{1'b0, 1'b1, 1'b1, 8'h55, 4'd1, 1'b0, 2'd1, 1'b1, 1'b0}, // R11 output disable
        '{1'b0, 1'b0, 1'b0, 8'h55, 4'd1, 1'b1, 2'd2, 1'b1, 1'b1}, // R13 write accepted
        '{1'b1, 1'b0, 1'b0, 8'h55, 4'd1, 1'b0, 2'd0, 1'b1, 1'b0}, // R7 standby
        '{1'b0, 1'b0, 1'b1, 8'h55, 4'd2, 1'b0, 2'd2, 1'b1, 1'b0}, // R8 restart after standby
        '{1'b1, 1'b1, 1'b1, 8'hAA, 4'd7, 1'b0, 2'd0, 1'b1, 1'b0}  // R10 independent of enables
    };

    function automatic string row_tag(input int i);
        case (i)
            0, 6, 7, 12: return "R10";
            1, 2, 11:    return "R8";
            3, 4, 5:     return "R9";
            8:           return "R11";
            9:           return "R13";
            default:     return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0; chip_en_n = 1'b1; out_en_n = 1'b1; wr_en_n = 1'b1;
        pin_rst_n = 1'b1; op_busy = 1'b0; addr = '0;
        tick(3);
        rst_n = 1'b1;
        #1;
        chk("R1", "dq_oe", dq_oe_o, 0);
        chk("R1", "abort", abort_o, 0);
        chk("R1", "sleep", sleep_o, 0);
        chk("R1", "wr_ok", wr_ok_o, 0);
        chk("R1", "ready", ready_o, 1);
        chk("R1", "mode", mode_o, 0);

        for (int i = 0; i < NV; i++) begin
            chip_en_n = TBL[i].ce_n;
            out_en_n  = TBL[i].oe_n;
            wr_en_n   = TBL[i].we_n;
            addr      = TBL[i].adr;
            tick(int'(TBL[i].n));
            chk(row_tag(i), $sformatf("row%0d dq_oe", i), dq_oe_o, TBL[i].dq);
            chk(row_tag(i), $sformatf("row%0d mode", i), mode_o, TBL[i].mode);
            chk(row_tag(i), $sformatf("row%0d sleep", i), sleep_o, TBL[i].slp);
            chk(row_tag(i), $sformatf("row%0d wr_ok", i), wr_ok_o, TBL[i].wr);
        end

        // R3: short reset pulse ignored while reading
        chip_en_n = 1'b0; out_en_n = 1'b0; wr_en_n = 1'b1;
        tick(3);
        chk("R3", "dq_oe before pulse", dq_oe_o, 1);
        pin_rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick(1);
            chk("R3", "abort in short pulse", abort_o, 0);
            chk("R3", "mode in short pulse", mode_o, 2);
            chk("R3", "dq_oe in short pulse", dq_oe_o, 1);
        end
        pin_rst_n = 1'b1;
        tick(1);
        chk("R3", "dq_oe after pulse", dq_oe_o, 1);
        chk("R3", "ready after pulse", ready_o, 1);

        // R2 / R5: valid reset with no operation running
        pin_rst_n = 1'b0;
        tick(3);
        chk("R2", "abort before T_RP", abort_o, 0);
        chk("R2", "mode before T_RP", mode_o, 2);
        tick(1);
        chk("R2", "abort at T_RP", abort_o, 1);
        chk("R2", "mode at T_RP", mode_o, 3);
        chk("R2", "dq_oe in reset", dq_oe_o, 0);
        chk("R5", "ready idle reset", ready_o, 1);
        wr_en_n = 1'b0;
        tick(1);
        chk("R2", "abort single cycle", abort_o, 0);
        chk("R2", "wr_ok in reset", wr_ok_o, 0);
        pin_rst_n = 1'b1;
        tick(1);
        chk("R11", "mode after release", mode_o, 2);
        chk("R5", "dq_oe in recovery", dq_oe_o, 0);
        tick(5);
        chk("R5", "wr_ok one edge before idle recovery", wr_ok_o, 0);
        tick(1);
        chk("R5", "wr_ok at idle recovery", wr_ok_o, 1);
        chk("R5", "ready after idle recovery", ready_o, 1);
        tick(2);
        chk("R8", "dq_oe one edge short after recovery", dq_oe_o, 0);
        tick(1);
        chk("R8", "dq_oe after recovery", dq_oe_o, 1);

        // R12: deselected during an embedded operation
        chip_en_n = 1'b1; op_busy = 1'b1;
        tick(3);
        chk("R12", "ready while busy deselected", ready_o, 0);
        chk("R12", "abort while busy deselected", abort_o, 0);
        chk("R7", "mode deselected", mode_o, 0);
        chk("R7", "dq_oe deselected oe low", dq_oe_o, 0);

        // R4 / R6: valid reset during an embedded operation
        chip_en_n = 1'b0; pin_rst_n = 1'b0;
        tick(4);
        chk("R4", "abort embedded", abort_o, 1);
        chk("R4", "ready at validation", ready_o, 0);
        op_busy = 1'b0;
        tick(19);
        chk("R4", "ready one edge before T_RDY_EMB", ready_o, 0);
        chk("R2", "mode pin held low", mode_o, 3);
        tick(1);
        chk("R4", "ready at T_RDY_EMB", ready_o, 1);
        chk("R13", "wr_ok pin still low", wr_ok_o, 0);
        pin_rst_n = 1'b1;
        tick(1);
        chk("R6", "mode after release", mode_o, 2);
        chk("R6", "wr_ok first high edge", wr_ok_o, 0);
        tick(2);
        chk("R6", "wr_ok one edge before T_RH", wr_ok_o, 0);
        tick(1);
        chk("R6", "wr_ok at T_RH", wr_ok_o, 1);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule